// File: doc/BRIEF.md
# FIFO-Fed Sample Playback Voice

This block is one audio voice of a cartridge bank-switching controller on an 8-bit CPU bus. The CPU pushes 8-bit unsigned samples into a 256-entry FIFO. While the FIFO holds data, a 12-bit period divider steps through the queued samples. The block turns each sample into a signed value, scales it by a 4-bit volume, and drives the product out. The voice switches itself on when data arrives and off when the queue runs dry. There is no separate enable.

The block takes a decoded write strobe, a 2-bit register index and the write data. It has four write targets: silence/clear (index 0), sample push (index 1), period low byte (index 2) and period high/volume (index 3). A readable status byte reports the FIFO state. A period written while a sample is playing waits in a pending register until the next sample boundary. A volume write changes the output on the next cycle.

Top module: `pcm_voice`

## Requirements
- R1: After reset the voice is inactive, `sampleOut` is 0 and `status` reads 0x40.
- R2: Each write to index 1 pushes one byte, and samples come out in the order they were pushed.
- R3: `status` bit 7 is set when 256 bytes are queued and bit 6 is set when none are queued. Bits 5:0 read 0. A push while the FIFO is full is dropped and overwrites nothing.
- R4: A write of any value to index 0 empties the FIFO. From the next cycle the voice is inactive, the output is 0 and `status` reads 0x40.
- R5: The period P is {index-3 bits 3:0, index-2 bits 7:0}. Each sample stays on the output for P+1 cycles.
- R6: A period written while a sample plays does not change that sample's duration. It applies from the next sample boundary.
- R7: Index-3 bits 7:4 set the volume. A new volume shows on the output in the cycle after the write.
- R8: While active, `sampleOut` equals (byte - 128) multiplied by the volume, as a signed 12-bit value.
- R9: A push into an empty FIFO makes `active` high in the next cycle, with the pushed byte on the output.
- R10: The voice goes inactive, with output 0, in the cycle after the last queued sample is popped.
- R11: A push in the same cycle as a pop keeps the queue length unchanged. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Decoded register write strobe |
| regSel | input | 2 | Register index: 0 silence, 1 push, 2 period low, 3 period high/volume |
| wrData | input | 8 | Write data |
| status | output | 8 | Bit 7 FIFO full, bit 6 FIFO empty, other bits 0 |
| active | output | 1 | High while the FIFO holds samples |
| sampleOut | output | 12 | Signed scaled sample, 0 when inactive |

## Verification
Two things can land on the same clock edge: a CPU push and the divider-driven pop. A register write can also land on a sample boundary. The bench sets the period to 3 and pushes a third byte so that its strobe covers exactly the edge where the first sample expires. It then checks that each of the three samples is held for four cycles and that the FIFO reports empty right after the third. A second sequence writes a new period during a playing sample and checks, cycle by cycle, that the old duration completes and the new one governs the following sample.

// File: rtl/pcm_voice_pkg.sv
package pcm_voice_pkg;
  localparam logic [1:0] SEL_SILENCE = 2'd0;
  localparam logic [1:0] SEL_PUSH    = 2'd1;
  localparam logic [1:0] SEL_PER_LO  = 2'd2;
  localparam logic [1:0] SEL_PER_HI  = 2'd3;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoCmd_t;
endpackage

// File: rtl/pcm_voice_ctrl.sv
module pcm_voice_ctrl
  import pcm_voice_pkg::*;
#(
  parameter int PERIOD_W = 12,
  parameter int VOL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       regSel,
  input  logic [7:0]       wrData,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  output fifoCmd_t         cmd,
  output logic [VOL_W-1:0] volume
);
  localparam int HI_W = PERIOD_W - 8;

  logic [7:0]          pendLo;
  logic [HI_W-1:0]     pendHi;
  logic [PERIOD_W-1:0] periodNext;
  logic [PERIOD_W-1:0] divCnt;
  logic                divDone;

  always_comb begin
    periodNext = {pendHi, pendLo};
    if (wrEn && regSel == SEL_PER_LO) periodNext[7:0] = wrData;
    if (wrEn && regSel == SEL_PER_HI) periodNext[PERIOD_W-1:8] = wrData[HI_W-1:0];
  end

  assign divDone   = (divCnt == '0);
  assign cmd.clear = wrEn && (regSel == SEL_SILENCE);
  assign cmd.push  = wrEn && (regSel == SEL_PUSH) && !fifoFull;
  assign cmd.pop   = !fifoEmpty && divDone && !cmd.clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendLo <= '0;
      pendHi <= '0;
      volume <= '0;
      divCnt <= '0;
    end else begin
      pendLo <= periodNext[7:0];
      pendHi <= periodNext[PERIOD_W-1:8];
      if (wrEn && regSel == SEL_PER_HI) volume <= wrData[7 -: VOL_W];
      if (cmd.clear || fifoEmpty || divDone) divCnt <= periodNext;
      else divCnt <= divCnt - 1'b1;
    end
  end
endmodule

// File: rtl/pcm_voice_fifo.sv
module pcm_voice_fifo
  import pcm_voice_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  parameter int VOL_W  = 4,
  parameter int OUT_W  = DATA_W + VOL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  fifoCmd_t                cmd,
  input  logic [DATA_W-1:0]       pushData,
  input  logic [VOL_W-1:0]        volume,
  output logic                    fifoEmpty,
  output logic                    fifoFull,
  output logic signed [OUT_W-1:0] sampleOut
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0]        mem [DEPTH];
  logic [AW-1:0]            wrPtr;
  logic [AW-1:0]            rdPtr;
  logic [AW:0]              count;
  logic [DATA_W-1:0]        head;
  logic signed [DATA_W-1:0] headSigned;
  logic signed [OUT_W:0]    product;

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + 1'b1;
      if (cmd.pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + {{AW{1'b0}}, cmd.push} - {{AW{1'b0}}, cmd.pop};
    end
  end

  assign fifoEmpty  = (count == '0);
  assign fifoFull   = (count == DEPTH[AW:0]);
  assign head       = mem[rdPtr];
  assign headSigned = $signed({~head[DATA_W-1], head[DATA_W-2:0]});
  assign product    = headSigned * $signed({1'b0, volume});
  assign sampleOut  = fifoEmpty ? '0 : product[OUT_W-1:0];
endmodule

// File: rtl/pcm_voice.sv
module pcm_voice
  import pcm_voice_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int PERIOD_W = 12,
  parameter int VOL_W    = 4,
  parameter int OUT_W    = 8 + VOL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrEn,
  input  logic [1:0]              regSel,
  input  logic [7:0]              wrData,
  output logic [7:0]              status,
  output logic                    active,
  output logic signed [OUT_W-1:0] sampleOut
);
  fifoCmd_t         cmd;
  logic             fifoEmpty;
  logic             fifoFull;
  logic [VOL_W-1:0] volume;

  pcm_voice_ctrl #(.PERIOD_W(PERIOD_W), .VOL_W(VOL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .cmd(cmd), .volume(volume)
  );

  pcm_voice_fifo #(.DEPTH(DEPTH), .DATA_W(8), .VOL_W(VOL_W), .OUT_W(OUT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .pushData(wrData), .volume(volume),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .sampleOut(sampleOut)
  );

  assign status = {fifoFull, fifoEmpty, 6'b0};
  assign active = !fifoEmpty;
endmodule

// File: rtl/pcm_voice_chk.sv
module pcm_voice_chk #(
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wrEn,
  input logic [1:0]              regSel,
  input logic [7:0]              status,
  input logic                    active,
  input logic signed [OUT_W-1:0] sampleOut
);
  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[6]));
  p_spare_bits_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[5:0] == 6'd0);
  p_silent_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sampleOut == '0);
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regSel == 2'd0) |=> (status == 8'h40 && !active));
  p_push_activates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regSel == 2'd1) |=> active);
  p_active_tracks_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active == !status[6]);
endmodule

bind pcm_voice pcm_voice_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regSel(regSel),
  .status(status), .active(active), .sampleOut(sampleOut)
);

// File: tb/sim_pcm_voice.sv
`timescale 1ns/1ps
module sim_pcm_voice;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] wrData = '0;
  logic [7:0] status;
  logic active;
  logic signed [11:0] sampleOut;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pcm_voice u0 (.clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regSel(regSel),
                .wrData(wrData), .status(status), .active(active), .sampleOut(sampleOut));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkOut(input string req, input int exp);
    check(int'(sampleOut) == exp, req, int'(sampleOut), exp);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPeriodVol(input int p, input int v);
    wr(2'd2, 8'(p));
    wr(2'd3, {4'(v), 4'(p >> 8)});
  endtask

  function automatic int sval(input int b, input int v);
    return (b - 128) * v;
  endfunction

  task automatic runLen(input string req, input int val, input int exp);
    int n = 0;
    while (int'(sampleOut) == val && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check(n == exp, req, n, exp);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(status == 8'h40, "R1 status", status, 8'h40);
    check(!active, "R1 active", active, 0);
    chkOut("R1 out", 0);

    // R8 R9 R4 R7: sweep every byte under several volumes
    foreach (sweepVol[vi]) ;
    for (int vi = 0; vi < 4; vi++) begin
      int v = (vi == 0) ? 0 : (vi == 1) ? 1 : (vi == 2) ? 8 : 15;
      setPeriodVol(200, v);
      for (int b = 0; b < 256; b++) begin
        wr(2'd1, 8'(b));
        check(active, "R9 activate", active, 1);
        check(status == 8'h00, "R9 status", status, 0);
        chkOut("R8 scaled", sval(b, v));
        wr(2'd0, 8'(b));
        check(!active && status == 8'h40, "R4 silence", status, 8'h40);
        chkOut("R4 out", 0);
      end
    end

    // R5 period composition and hold length
    for (int pi = 0; pi < 4; pi++) begin
      int p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 5 : 300;
      setPeriodVol(p, 1);
      wr(2'd1, 8'h90);
      wr(2'd1, 8'h20);
      runLen("R5 hold", sval(8'h90, 1) , p); // one cycle already elapsed during second push
      runLen("R5 second", sval(8'h20, 1), p + 1);
      check(!active, "R10 idle after drain", active, 0);
      chkOut("R10 out", 0);
    end

    // R6 deferred period
    wr(2'd0, 8'h00);
    setPeriodVol(4, 1);
    wr(2'd1, 8'hA0);               // n0: A loaded with 4
    wr(2'd1, 8'hB0);               // n1
    wr(2'd1, 8'hC0);               // n2
    wr(2'd2, 8'h02);               // n3: new period pending
    chkOut("R6 A n3", sval(8'hA0, 1));
    @(negedge clk); chkOut("R6 A n4", sval(8'hA0, 1));
    @(negedge clk); chkOut("R6 B n5", sval(8'hB0, 1));
    @(negedge clk); @(negedge clk); chkOut("R6 B n7", sval(8'hB0, 1));
    @(negedge clk); chkOut("R6 C n8", sval(8'hC0, 1));
    wr(2'd0, 8'h00);

    // R7 volume applies immediately
    setPeriodVol(100, 1);
    wr(2'd1, 8'hC0);
    chkOut("R7 before", 64);
    wr(2'd3, 8'h90);
    chkOut("R7 after", 576);
    wr(2'd0, 8'h00);

    // R11 push coinciding with pop, R2 order
    setPeriodVol(3, 1);
    wr(2'd1, 8'h11);               // E0
    wr(2'd1, 8'h22);               // E1
    chkOut("R2 A n1", sval(8'h11, 1));
    @(negedge clk); chkOut("R2 A n2", sval(8'h11, 1));
    @(negedge clk); chkOut("R2 A n3", sval(8'h11, 1));
    wr(2'd1, 8'h33);               // strobe covers the pop edge E4
    for (int k = 0; k < 4; k++) begin
      chkOut("R11 B", sval(8'h22, 1));
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      chkOut("R11 C", sval(8'h33, 1));
      @(negedge clk);
    end
    check(status == 8'h40, "R11 empty after three", status, 8'h40);

    // R3 full, overflow ignored, R2 order over whole depth
    setPeriodVol(4095, 1);
    for (int i = 0; i < 256; i++) begin
      wr(2'd1, 8'(i));
      if (i == 254) check(status == 8'h00, "R3 not full at 255", status, 0);
    end
    check(status == 8'h80, "R3 full", status, 8'h80);
    wr(2'd1, 8'h07);
    check(status == 8'h80, "R3 still full", status, 8'h80);
    chkOut("R3 head kept", -128);
    setPeriodVol(0, 1);
    begin
      int n = 0;
      while (int'(sampleOut) == -128 && n < 6000) begin
        n++;
        @(negedge clk);
      end
    end
    for (int k = 1; k < 256; k++) begin
      chkOut("R2 drain order", k - 128);
      @(negedge clk);
    end
    check(!active && status == 8'h40, "R3 extra push dropped", status, 8'h40);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  int sweepVol[1];

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule